// File: doc/BRIEF.md
# UART Frame Engine with In-Field Parity

This block serialises and deserialises asynchronous frames with a programmable field width, stop-bit count and parity. A frame is a low start bit, the data field least-significant bit first, and one or two high stop bits. The field is 8 or 9 bits wide. When parity is enabled it takes no extra bit slot. The top bit of the field carries the computed parity in place of the written data bit, and the receiver checks that same position.

The host loads a 9-bit word with a single-cycle strobe. A 9-bit register shows the last received field, and a one-cycle pulse marks each new one. Two sticky flags report receive errors: a parity mismatch and a low stop bit. Both clear only after a status read followed by a data-register access, and the parity flag can drive an interrupt. One bit period is a fixed number of clock cycles, set by a parameter.

Top module: `uart_parity_engine`

## Requirements
- R1: The idle line is high. A frame is one low start bit, then the field bits least-significant first, then high stop bits, and each bit lasts BIT_CYCLES clocks. The first start-bit cycle follows the clock edge that samples `tx_load`.
- R2: With `word9`=0 the field is 8 bits (tx_data[7:0]). With `word9`=1 it is 9 bits (tx_data[8:0]).
- R3: With `par_en`=1 the top field bit (bit 7 for 8-bit frames, bit 8 for 9-bit frames) is replaced by parity over the bits below it. Even parity is used when `par_odd`=0 and odd parity when `par_odd`=1. For example, a low part of 0110101 gives parity bit 0 (even) or 1 (odd).
- R4: With `par_en`=0 every field bit is sent exactly as written.
- R5: `stop2`=0 gives one stop bit and `stop2`=1 gives two. `tx_busy` stays high for (1 + field bits + stop bits) × BIT_CYCLES cycles.
- R6: The receiver samples each bit near its middle and stores the whole received field, parity position included, in `rx_data`. Bits above the field width read as 0. `rx_valid` pulses for one cycle, and `rx_data` changes only on that cycle.
- R7: When `par_en`=1 and the number of ones in the received field does not match `par_odd`, `par_err` is set. `par_irq` is high whenever `par_err` and `par_irq_en` are both high.
- R8: A first stop bit sampled low sets `frm_err`.
- R9: Both error flags clear when a `stat_rd` strobe is followed by a data access (`data_rd` or `tx_load`). A status read on its own, or a data access with no status read before it, leaves the flags unchanged.
- R10: A `tx_load` while `tx_busy` is high does not alter the frame in flight or its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word9 | input | 1 | 1 = 9-bit field, 0 = 8-bit field |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| stop2 | input | 1 | 1 = two stop bits |
| tx_data | input | 9 | Word to transmit |
| tx_load | input | 1 | Data-register write strobe, starts a frame when idle |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_data | output | 9 | Last received field |
| rx_valid | output | 1 | New field pulse |
| stat_rd | input | 1 | Status register read strobe |
| data_rd | input | 1 | Data register read strobe |
| par_irq_en | input | 1 | Parity interrupt enable |
| par_err | output | 1 | Sticky parity error |
| par_irq | output | 1 | Parity interrupt |
| frm_err | output | 1 | Sticky framing error |

## Verification
The bench checks the replaced top bit on both field widths and both parity senses. A design that appended parity, or computed it over the full field, would shift or corrupt the captured bit sequence. It drives hand-built frames with bad parity and a low stop bit, then runs the clear sequence in the wrong orders. A flag that cleared on a bare data read, or on a status read alone, would read 0 where 1 is expected. It also times `tx_busy` with two stop bits and fires a second load mid-frame. A miscounted stop phase or an accepted second load would change the measured length or the captured bits.

// File: rtl/uart_par_pkg.sv
package uart_par_pkg;

    localparam int FIELD_W = 9;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT_HI
    } rx_state_e;

    typedef struct packed {
        logic word9;
        logic par_en;
        logic par_odd;
        logic stop2;
    } frame_cfg_t;

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               par_bad;
        logic               stop_bad;
    } rx_result_t;

    function automatic logic [3:0] field_bits(input logic word9);
        return word9 ? 4'd9 : 4'd8;
    endfunction

    function automatic logic [FIELD_W-1:0] below_top_mask(input logic word9);
        return word9 ? 9'h0FF : 9'h07F;
    endfunction

    // Field as sent: top bit swapped for parity when parity is on.
    function automatic logic [FIELD_W-1:0] tx_field(input logic [FIELD_W-1:0] d,
                                                    input frame_cfg_t c);
        logic [FIELD_W-1:0] f;
        logic               p;
        f = c.word9 ? d : {1'b0, d[7:0]};
        p = (^(d & below_top_mask(c.word9))) ^ c.par_odd;
        if (c.par_en) begin
            if (c.word9) f[8] = p;
            else         f[7] = p;
        end
        return f;
    endfunction

    function automatic logic rx_parity_bad(input logic [FIELD_W-1:0] f,
                                           input frame_cfg_t c);
        return c.par_en && ((^f) != c.par_odd);
    endfunction

endpackage

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_par_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  frame_cfg_t         cfg,
    input  logic               load,
    input  logic [FIELD_W-1:0] data,
    output logic               txd,
    output logic               busy
);
    localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    tx_state_e          state;
    logic [CW-1:0]      cnt;
    logic [3:0]         idx;
    logic [FIELD_W-1:0] shreg;
    frame_cfg_t         cfg_q;
    logic               bit_end;

    assign bit_end = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            shreg <= '0;
            cfg_q <= '0;
        end else begin
            if (state != TX_IDLE) cnt <= bit_end ? '0 : cnt + 1'b1;
            unique case (state)
                TX_IDLE: begin
                    cnt <= '0;
                    idx <= '0;
                    if (load) begin
                        shreg <= tx_field(data, cfg);
                        cfg_q <= cfg;
                        state <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        state <= TX_DATA;
                        idx   <= '0;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        shreg <= shreg >> 1;
                        if (idx == field_bits(cfg_q.word9) - 4'd1) begin
                            state <= TX_STOP;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 4'd1;
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        if (cfg_q.stop2 && idx == 4'd0) idx <= 4'd1;
                        else                             state <= TX_IDLE;
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            default:  txd = 1'b1;
        endcase
    end

    assign busy = (state != TX_IDLE);

endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
    import uart_par_pkg::*;
#(
    parameter int BIT_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  frame_cfg_t cfg,
    input  logic       rxd,
    output logic       valid,
    output rx_result_t result
);
    localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);
    localparam logic [CW-1:0] MID  = CW'(BIT_CYCLES / 2 - 1);

    logic [SYNC_STAGES-1:0] sync;
    logic                   rxs;
    rx_state_e              state;
    logic [CW-1:0]          cnt;
    logic [3:0]             idx;
    logic [FIELD_W-1:0]     shreg;
    logic [FIELD_W-1:0]     field;

    // Input synchronizer, depth chosen by parameter.
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) sync[0] <= rst ? 1'b1 : rxd;
            end else begin : g_next
                always_ff @(posedge clk) sync[g] <= rst ? 1'b1 : sync[g-1];
            end
        end
    endgenerate

    assign rxs   = sync[SYNC_STAGES-1];
    assign field = cfg.word9 ? shreg : {1'b0, shreg[8:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            shreg  <= '0;
            valid  <= 1'b0;
            result <= '0;
        end else begin
            valid <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    cnt <= '0;
                    if (!rxs) state <= RX_START;
                end
                RX_START: begin
                    if (cnt == MID) begin
                        cnt   <= '0;
                        idx   <= '0;
                        state <= rxs ? RX_IDLE : RX_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        shreg <= {rxs, shreg[8:1]};
                        if (idx == field_bits(cfg.word9) - 4'd1) state <= RX_STOP;
                        else                                      idx   <= idx + 4'd1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (cnt == LAST) begin
                        cnt             <= '0;
                        valid           <= 1'b1;
                        result.field    <= field;
                        result.par_bad  <= rx_parity_bad(field, cfg);
                        result.stop_bad <= !rxs;
                        state           <= rxs ? RX_IDLE : RX_WAIT_HI;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RX_WAIT_HI: begin
                    if (rxs) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/uart_err_flags.sv
module uart_err_flags (
    input  logic clk,
    input  logic rst,
    input  logic set_par,
    input  logic set_frm,
    input  logic stat_rd,
    input  logic data_acc,
    output logic par_err,
    output logic frm_err
);
    logic armed;
    logic clr;

    assign clr = armed && data_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            if (data_acc)     armed <= 1'b0;
            else if (stat_rd) armed <= 1'b1;
            par_err <= set_par | (par_err & ~clr);
            frm_err <= set_frm | (frm_err & ~clr);
        end
    end

endmodule

// File: rtl/uart_parity_engine.sv
module uart_parity_engine
    import uart_par_pkg::*;
#(
    parameter int BIT_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       word9,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       stop2,
    input  logic [8:0] tx_data,
    input  logic       tx_load,
    output logic       tx_busy,
    output logic       txd,
    input  logic       rxd,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    input  logic       stat_rd,
    input  logic       data_rd,
    input  logic       par_irq_en,
    output logic       par_err,
    output logic       par_irq,
    output logic       frm_err
);
    frame_cfg_t cfg;
    rx_result_t res;
    logic       rx_pulse;

    assign cfg = '{word9: word9, par_en: par_en, par_odd: par_odd, stop2: stop2};

    uart_tx_frame #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk  (clk),
        .rst  (rst),
        .cfg  (cfg),
        .load (tx_load),
        .data (tx_data),
        .txd  (txd),
        .busy (tx_busy)
    );

    uart_rx_frame #(.BIT_CYCLES(BIT_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .cfg    (cfg),
        .rxd    (rxd),
        .valid  (rx_pulse),
        .result (res)
    );

    uart_err_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_par  (rx_pulse & res.par_bad),
        .set_frm  (rx_pulse & res.stop_bad),
        .stat_rd  (stat_rd),
        .data_acc (data_rd | tx_load),
        .par_err  (par_err),
        .frm_err  (frm_err)
    );

    assign rx_data  = res.field;
    assign rx_valid = rx_pulse;
    assign par_irq  = par_err & par_irq_en;

endmodule

// File: rtl/uart_parity_engine_chk.sv
module uart_parity_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_load,
    input logic       tx_busy,
    input logic       txd,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       data_rd,
    input logic       par_err,
    input logic       frm_err
);
    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_busy |-> txd);

    // R1
    frame_needs_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_busy) |-> $past(tx_load));

    // R6
    rx_data_only_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> rx_valid);

    // R7
    par_err_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(par_err) |-> $past(rx_valid));

    // R8
    frm_err_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frm_err) |-> $past(rx_valid));

    // R9
    par_clear_on_access_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(par_err) |-> $past(data_rd || tx_load));

    // R9
    frm_clear_on_access_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frm_err) |-> $past(data_rd || tx_load));

endmodule

bind uart_parity_engine uart_parity_engine_chk u_chk (.*);

// File: tb/sim_uart_parity_engine.sv
module sim_uart_parity_engine;
    localparam int B = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       word9 = 1'b0, par_en = 1'b0, par_odd = 1'b0, stop2 = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic       tx_busy, txd, rx_valid, par_err, par_irq, frm_err;
    logic [8:0] rx_data;
    logic       stat_rd = 1'b0, data_rd = 1'b0, par_irq_en = 1'b0;
    logic       loop = 1'b1, rxd_drv = 1'b1;
    logic       rxd;

    int errors = 0, checks = 0, rx_cnt = 0;
    logic [8:0] rx_last = '0;
    bit done = 0;

    assign rxd = loop ? txd : rxd_drv;

    always #5 clk = ~clk;

    uart_parity_engine #(.BIT_CYCLES(B)) u0 (
        .clk(clk), .rst(rst), .word9(word9), .par_en(par_en), .par_odd(par_odd),
        .stop2(stop2), .tx_data(tx_data), .tx_load(tx_load), .tx_busy(tx_busy),
        .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
        .stat_rd(stat_rd), .data_rd(data_rd), .par_irq_en(par_irq_en),
        .par_err(par_err), .par_irq(par_irq), .frm_err(frm_err)
    );

    always @(negedge clk) if (rx_valid) begin
        rx_cnt++;
        rx_last = rx_data;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected field computed from the requirements.
    function automatic logic [8:0] exp_field(input logic [8:0] d);
        int n;
        int ones;
        logic [8:0] f;
        n = word9 ? 9 : 8;
        f = '0;
        ones = 0;
        for (int i = 0; i < n; i++) f[i] = d[i];
        if (par_en) begin
            for (int i = 0; i < n - 1; i++) ones += int'(d[i]);
            f[n-1] = ((ones % 2) == 1) ^ par_odd;
        end
        return f;
    endfunction

    task automatic cfg_set(input logic w9, input logic pe, input logic po, input logic s2);
        @(negedge clk);
        word9 = w9; par_en = pe; par_odd = po; stop2 = s2;
    endtask

    task automatic strobe(input bit do_stat, input bit do_data);
        @(negedge clk);
        stat_rd = do_stat; data_rd = do_data;
        @(negedge clk);
        stat_rd = 0; data_rd = 0;
    endtask

    // Sends one word, captures every bit mid-period and times tx_busy.
    task automatic send(input logic [8:0] d, input bit inject,
                        output logic [11:0] bits, output int busy_n);
        int n;
        n = word9 ? 9 : 8;
        bits = '1;
        busy_n = 0;
        @(negedge clk);
        tx_data = d; tx_load = 1;
        @(negedge clk);
        tx_load = 0;
        fork
            begin
                int pos;
                pos = 0;
                for (int j = 0; j < n + 2; j++) begin
                    repeat (j * B + B / 2 - pos) @(negedge clk);
                    pos = j * B + B / 2;
                    bits[j] = txd;
                end
            end
            begin
                while (tx_busy) begin
                    busy_n++;
                    @(negedge clk);
                end
            end
            begin
                if (inject) begin
                    repeat (3 * B) @(negedge clk);
                    tx_data = ~d; tx_load = 1;
                    @(negedge clk);
                    tx_load = 0;
                end
            end
        join
        repeat (B) @(negedge clk);
    endtask

    function automatic logic [11:0] exp_bits(input logic [8:0] f);
        int n;
        logic [11:0] e;
        n = word9 ? 9 : 8;
        e = '1;
        e[0] = 1'b0;
        for (int i = 0; i < n; i++) e[i+1] = f[i];
        e[n+1] = 1'b1;
        return e;
    endfunction

    task automatic drive_frame(input logic [8:0] f, input logic stop_lvl);
        int n;
        n = word9 ? 9 : 8;
        loop = 0;
        @(negedge clk);
        rxd_drv = 0;
        repeat (B) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            rxd_drv = f[i];
            repeat (B) @(negedge clk);
        end
        rxd_drv = stop_lvl;
        repeat (B) @(negedge clk);
        rxd_drv = 1;
        repeat (3 * B) @(negedge clk);
        loop = 1;
    endtask

    task automatic t_reset;
        chk(txd == 1'b1, "R1 idle txd", 32'(txd), 1);
        chk(tx_busy == 1'b0, "R1 idle busy", 32'(tx_busy), 0);
        chk({par_err, frm_err, par_irq} == 3'b000, "R9 reset flags",
            32'({par_err, frm_err, par_irq}), 0);
    endtask

    task automatic t_frame(input logic [8:0] d, input string req);
        logic [11:0] bits;
        int bn, n, s, c0;
        n = word9 ? 9 : 8;
        s = stop2 ? 2 : 1;
        c0 = rx_cnt;
        send(d, 1'b0, bits, bn);
        chk(bits == exp_bits(exp_field(d)), req, 32'(bits), 32'(exp_bits(exp_field(d))));
        chk(bn == (1 + n + s) * B, "R5 busy length", 32'(bn), 32'((1 + n + s) * B));
        chk(rx_cnt == c0 + 1 && rx_last == exp_field(d), "R6 loopback field",
            32'(rx_last), 32'(exp_field(d)));
        chk(par_err == 1'b0, "R7 no parity error on good frame", 32'(par_err), 0);
    endtask

    task automatic t_bad_parity;
        cfg_set(1'b0, 1'b1, 1'b0, 1'b0);
        par_irq_en = 0;
        drive_frame(9'h0B5, 1'b1);   // five ones: wrong under even parity
        chk(par_err == 1'b1, "R7 parity error set", 32'(par_err), 1);
        chk(par_irq == 1'b0, "R7 irq masked", 32'(par_irq), 0);
        chk(rx_last == 9'h0B5, "R6 parity position kept", 32'(rx_last), 32'h0B5);
        @(negedge clk) par_irq_en = 1;
        @(negedge clk);
        chk(par_irq == 1'b1, "R7 irq enabled", 32'(par_irq), 1);
        strobe(0, 1);
        chk(par_err == 1'b1, "R9 data read alone keeps flag", 32'(par_err), 1);
        strobe(1, 0);
        chk(par_err == 1'b1, "R9 status read alone keeps flag", 32'(par_err), 1);
        strobe(0, 1);
        chk(par_err == 1'b0, "R9 status then data clears", 32'(par_err), 0);
        par_irq_en = 0;
    endtask

    task automatic t_framing;
        logic [11:0] bits;
        int bn;
        cfg_set(1'b1, 1'b0, 1'b0, 1'b0);
        drive_frame(9'h155, 1'b0);
        chk(frm_err == 1'b1, "R8 low stop sets frm_err", 32'(frm_err), 1);
        chk(par_err == 1'b0, "R8 parity off no par_err", 32'(par_err), 0);
        strobe(1, 0);
        send(9'h001, 1'b0, bits, bn);  // write access completes the clear
        chk(frm_err == 1'b0, "R9 status then write clears", 32'(frm_err), 0);
    endtask

    task automatic t_busy_load;
        logic [11:0] bits;
        int bn;
        cfg_set(1'b0, 1'b0, 1'b0, 1'b1);
        send(9'h0C3, 1'b1, bits, bn);
        chk(bits == exp_bits(exp_field(9'h0C3)), "R10 frame unchanged",
            32'(bits), 32'(exp_bits(exp_field(9'h0C3))));
        chk(bn == 11 * B, "R10 length unchanged", 32'(bn), 32'(11 * B));
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        t_reset();
        cfg_set(1'b0, 1'b0, 1'b0, 1'b0);
        t_frame(9'h0A5, "R1 R4 8-bit plain frame");
        cfg_set(1'b1, 1'b0, 1'b0, 1'b0);
        t_frame(9'h1A5, "R2 9-bit plain frame");
        cfg_set(1'b0, 1'b1, 1'b0, 1'b0);
        t_frame(9'h0B5, "R3 8-bit even parity");
        cfg_set(1'b0, 1'b1, 1'b1, 1'b0);
        t_frame(9'h035, "R3 8-bit odd parity");
        cfg_set(1'b1, 1'b1, 1'b0, 1'b1);
        t_frame(9'h0FF, "R3 9-bit even parity two stops");
        cfg_set(1'b1, 1'b1, 1'b1, 1'b1);
        t_frame(9'h071, "R3 R5 9-bit odd parity two stops");
        t_bad_parity();
        t_framing();
        t_busy_load();
        finish_run();
    end

endmodule